// File: doc/BRIEF.md
# Watchdog Tick Prescaler with Selectable Tap

This block produces the single-cycle count enable that steps a watchdog down counter. It runs entirely on the system clock and derives no other clocks. An internal stage first makes a machine-cycle enable, one clock in every twelve. A free-running binary counter advances on that enable. A 3-bit tap code picks how many of the counter's low bits must all roll over before an output tick is issued.

With the default parameters the smallest tap divides the machine-cycle rate by 64. Each step up in the tap code doubles the divisor, up to 8192 for the largest code. The tap code may be changed at any time. The counter is not cleared when the code changes, so the first tick after a change can arrive early. Every tick after that is spaced exactly.

Top module: `wdt_prescaler_top`

## Requirements
- R1: The machine-cycle enable is high for one clock in every PRE_DIV clocks (default 12), and the tap counter advances only on that enable.
- R2: With a steady tap code `s`, successive `wd_tick` pulses are spaced exactly PRE_DIV × 2^(BASE_LOG2 + s) clocks apart. The code is unsigned and ascending, so with the defaults code 0 gives a divisor of 64, code 1 gives 128, and so on up to code 7, which gives 8192.
- R3: `wd_tick` is high for exactly one clock per pulse.
- R4: While `rst` is high, `wd_tick` stays low and both internal counters are held at zero. After `rst` is sampled low, the first pulse appears after the clock edge numbered PRE_DIV × 2^(BASE_LOG2 + s) + 1, counting the first edge with `rst` low as edge 1.
- R5: A change of `tap_sel` does not clear the counter. The next pulse follows the first enable on which the counter's low BASE_LOG2 + s bits are all ones under the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tap_sel | input | 3 | Tap code; the divisor is 2^(BASE_LOG2 + code) machine cycles |
| wd_tick | output | 1 | Registered single-cycle count enable for the watchdog counter |

## Verification
The assertions assume that `rst` is high at the first clock edge and that the shortest tap spans several machine cycles. Under those conditions two ticks can never fall on adjacent clocks. The stimulus drives `rst` high from time zero and changes `tap_sel` only between clock edges. The bench uses a smaller BASE_LOG2, so that the interval for every one of the eight codes can be measured within the run. All expected intervals are derived from that parameter.

// File: rtl/wdtp_pkg.sv
package wdtp_pkg;
  localparam int DEF_PRE_DIV   = 12;
  localparam int DEF_BASE_LOG2 = 6;
  localparam int DEF_SEL_W     = 3;

  // counter width: base stage plus one bit per extra tap
  function automatic int chain_width(input int base_log2, input int sel_w);
    return base_log2 + (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/mc_enable_gen.sv
module mc_enable_gen #(
  parameter int PRE_DIV = wdtp_pkg::DEF_PRE_DIV
) (
  input  logic clk,
  input  logic rst,
  output logic mc_en
);
  localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      mc_en   <= 1'b0;
    end else begin
      mc_en   <= (div_cnt == LAST);
      div_cnt <= (div_cnt == LAST) ? '0 : div_cnt + 1'b1;
    end
  end

  generate
    if (PRE_DIV > 1) begin : g_spacing_chk
      a_r1_enable_isolated: assert property (@(posedge clk) disable iff (rst)
        mc_en |=> !mc_en);
    end
  endgenerate
endmodule

// File: rtl/tap_mask_decode.sv
module tap_mask_decode #(
  parameter int BASE_LOG2 = wdtp_pkg::DEF_BASE_LOG2,
  parameter int SEL_W     = wdtp_pkg::DEF_SEL_W,
  parameter int CNT_W     = wdtp_pkg::chain_width(BASE_LOG2, SEL_W)
) (
  input  logic [SEL_W-1:0] tap_sel,
  output logic [CNT_W-1:0] low_mask
);
  // bit i belongs to the rollover window when i < BASE_LOG2 + tap_sel
  generate
    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
      if (i < BASE_LOG2) begin : g_fixed
        assign low_mask[i] = 1'b1;
      end else begin : g_sel
        assign low_mask[i] = (int'(tap_sel) > (i - BASE_LOG2));
      end
    end
  endgenerate
endmodule

// File: rtl/tap_counter.sv
module tap_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] low_mask,
  output logic             tick
);
  logic [CNT_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= step && ((chain_q & low_mask) == low_mask);
      if (step) chain_q <= chain_q + 1'b1;
    end
  end

  a_r5_step_increments: assert property (@(posedge clk) disable iff (rst)
    step |=> (chain_q == CNT_W'($past(chain_q) + 1'b1)));
  a_r1_hold_without_step: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(chain_q));
  a_r2_tick_follows_step: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(step));
  a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  a_r4_reset_quiet: assert property (@(posedge clk)
    rst |=> (!tick && chain_q == '0));
endmodule

// File: rtl/wdt_prescaler_top.sv
module wdt_prescaler_top #(
  parameter int PRE_DIV   = wdtp_pkg::DEF_PRE_DIV,
  parameter int BASE_LOG2 = wdtp_pkg::DEF_BASE_LOG2,
  parameter int SEL_W     = wdtp_pkg::DEF_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             wd_tick
);
  localparam int CNT_W = wdtp_pkg::chain_width(BASE_LOG2, SEL_W);

  logic             mc_en;
  logic [CNT_W-1:0] low_mask;

  mc_enable_gen #(.PRE_DIV(PRE_DIV)) u_mc (
    .clk   (clk),
    .rst   (rst),
    .mc_en (mc_en)
  );

  tap_mask_decode #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_mask (
    .tap_sel  (tap_sel),
    .low_mask (low_mask)
  );

  tap_counter #(.CNT_W(CNT_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .step     (mc_en),
    .low_mask (low_mask),
    .tick     (wd_tick)
  );
endmodule

// File: tb/tb_wdt_prescaler_top.sv
module tb_wdt_prescaler_top;
  localparam int PD = 12;
  localparam int B  = 4;   // reduced base so all eight taps fit in the run
  localparam int NV = 8;

  localparam int VEC_SEL [NV] = '{0, 3, 1, 7, 2, 5, 4, 6};
  localparam int VEC_EXP [NV] = '{PD << (B + 0), PD << (B + 3), PD << (B + 1), PD << (B + 7),
                                  PD << (B + 2), PD << (B + 5), PD << (B + 4), PD << (B + 6)};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = '0;
  logic       tick;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  wdt_prescaler_top #(.PRE_DIV(PD), .BASE_LOG2(B), .SEL_W(3)) dut (
    .clk     (clk),
    .rst     (rst),
    .tap_sel (sel),
    .wd_tick (tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges until tick is seen high; -1 if it never appears
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 30000);
    if (!tick) n = -1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int first_i;
    int seen;
    int n;

    // R4: output held low in reset
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, "R4 tick during reset", seen, 0);

    // R4: first pulse after release, code 0
    rst = 1'b0;
    first_i = -1;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (tick && first_i < 0) first_i = i;
    end
    check(first_i == (PD << B) + 1, "R4 first tick edge", first_i, (PD << B) + 1);

    // R5: switch to code 1 without clearing the counter
    sel = 3'd1;
    first_i = -1;
    for (int i = 301; i <= 500; i++) begin
      @(negedge clk);
      if (tick && first_i < 0) first_i = i;
    end
    check(first_i == (PD << (B + 1)) + 1, "R5 tick after code change", first_i,
          (PD << (B + 1)) + 1);

    // R1 R2 R3: interval table
    for (int v = 0; v < NV; v++) begin
      sel = 3'(VEC_SEL[v]);
      wait_tick(n);
      @(negedge clk);
      check(!tick, "R3 pulse width", int'(tick), 0);
      wait_tick(n);
      if (n > 0) n = n + 1;
      check(n == VEC_EXP[v], $sformatf("R2 R1 interval code %0d", VEC_SEL[v]), n, VEC_EXP[v]);
    end

    // R4: mid-run reset clears state and restarts timing
    sel = 3'd0;
    rst = 1'b1;
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, "R4 tick during mid-run reset", seen, 0);
    rst = 1'b0;
    first_i = -1;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (tick && first_i < 0) first_i = i;
    end
    check(first_i == (PD << B) + 1, "R4 first tick after mid-run reset", first_i, (PD << B) + 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule